// File: doc/BRIEF.md
# LCD Frame Clock Generator

This block produces the frame timing for a segment LCD driver from a slow LCD source clock. It runs entirely in the LCD clock domain. It produces clock enables rather than derived clocks. Three counter stages are chained. A power-of-two prescaler divides the source clock by N. An integer divider divides the prescaler pulses by D, which can be 1 to 8. A last stage divides by K, which depends on the drive duty. The result is one frame pulse every K·N·D source cycles.

Configuration arrives as a control byte plus a separate 2-bit duty select. The byte carries the enable, the prescaler select, a reserved bit and the divide code. The block captures the configuration while it is disabled and again at each frame pulse. Every frame therefore runs with a single, coherent setting. The captured setting can be read back as a byte.

The parameter `PRESC_SHIFT_DROP` shrinks every prescaler factor by the same power of two. The ratios between select codes stay the same. At the default of 0 the factors are the full-size ones listed in R1.

Top module: `lcd_frame_clk`

## Requirements
- R1: `pre_tick_o` is high for one cycle every N cycles. N is set by `ctrl_i[6:4]`: 000→16, 001→64, 010→128, 011→256, 100→512, 101→1024, 110→2048, 111→4096. Each value is shifted right by `PRESC_SHIFT_DROP`, with a minimum of 1.
- R2: `div_tick_o` is high for one cycle every D prescaler pulses, where D is the code in `ctrl_i[2:0]` plus one (1 to 8).
- R3: `frame_tick_o` is high for exactly one cycle every K·N·D cycles. K is 6 when `duty_i` is 10 (1/3 duty). K is 8 when `duty_i` is 00 (static), 01 (1/2) or 11 (1/4).
- R4: `ctrl_o` reads back the captured setting. Bit 7 is the running state, bits 6:4 are the prescaler select and bits 2:0 are the divide code. Bit 3 is reserved: it always reads 0, and a 1 written to `ctrl_i[3]` has no effect on the output or on any period.
- R5: A change to the select, divide or duty inputs while running leaves the current frame period unchanged. The new setting governs the period that starts after the next frame pulse.
- R6: While `ctrl_i[7]` is 0, all counters are held at zero, no tick output is asserted, and the setting tracks the inputs. Once enabled, the first frame pulse appears K·N·D cycles after the first clock edge that samples the enable high.
- R7: After reset all outputs, including `ctrl_o`, are 0.
- R8: Each frame pulse coincides with a divider pulse and a prescaler pulse. Each frame period holds K·D prescaler pulses and K divider pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | LCD source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Control byte: enable, prescaler select, reserved, divide code |
| duty_i | input | 2 | Duty select, which sets K |
| ctrl_o | output | 8 | Captured setting read back, reserved bit 0 |
| pre_tick_o | output | 1 | Prescaler clock enable |
| div_tick_o | output | 1 | Divider clock enable |
| frame_tick_o | output | 1 | One-cycle pulse per frame |

## Verification
The bench builds the block with `PRESC_SHIFT_DROP` = 4, so N runs from 1 to 256 and the longest frame is a few thousand cycles. At that size every divide code can be measured against both K values for the four smallest prescaler settings. The remaining select codes and the static and 1/4 duties are measured over a wide enough slice to cover every encoding. The reduced size also makes room for a mid-frame reconfiguration, a disable and restart with an exact first-pulse latency, and reserved-bit writes interleaved across the sweep.

// File: rtl/lcd_fclk_pkg.sv
`timescale 1ns/1ps
package lcd_fclk_pkg;

  typedef enum logic [1:0] {
    DUTY_STATIC  = 2'b00,
    DUTY_HALF    = 2'b01,
    DUTY_THIRD   = 2'b10,
    DUTY_QUARTER = 2'b11
  } duty_e;

  typedef struct packed {
    logic [2:0] presc;
    logic [2:0] div;
    duty_e      duty;
  } cfg_t;

  // full-size prescaler exponent: 4, 6, 7, ... 12
  function automatic int unsigned presc_log2(input logic [2:0] sel);
    return (sel == 3'd0) ? 32'd4 : 32'(sel) + 32'd5;
  endfunction

endpackage

// File: rtl/lcd_fclk_stage.sv
`timescale 1ns/1ps
module lcd_fclk_stage #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == last_i);
  assign tick_o = step_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R1/R2/R3: the modulus only changes while the count is at zero
  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q <= last_i);

endmodule

// File: rtl/lcd_fclk_cfg.sv
`timescale 1ns/1ps
module lcd_fclk_cfg
  import lcd_fclk_pkg::*;
#(
  parameter int unsigned SHIFT_DROP = 0,
  parameter int unsigned PW         = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [2:0]    presc_i,
  input  logic [2:0]    div_i,
  input  logic [1:0]    duty_i,
  output cfg_t          cfg_o,
  output logic [PW-1:0] n_last_o,
  output logic [2:0]    d_last_o,
  output logic [2:0]    k_last_o
);

  cfg_t        cfg_q;
  int unsigned exp_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '{presc: 3'd0, div: 3'd0, duty: DUTY_STATIC};
    else if (load_i) cfg_q <= '{presc: presc_i, div: div_i, duty: duty_e'(duty_i)};
  end

  always_comb begin
    exp_w    = presc_log2(cfg_q.presc);
    exp_w    = (exp_w > SHIFT_DROP) ? exp_w - SHIFT_DROP : 32'd0;
    n_last_o = PW'((64'd1 << exp_w) - 64'd1);
    d_last_o = cfg_q.div;
    k_last_o = (cfg_q.duty == DUTY_THIRD) ? 3'd5 : 3'd7;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/lcd_frame_clk.sv
`timescale 1ns/1ps
module lcd_frame_clk
  import lcd_fclk_pkg::*;
#(
  parameter int unsigned PRESC_SHIFT_DROP = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] ctrl_i,
  input  logic [1:0] duty_i,
  output logic [7:0] ctrl_o,
  output logic       pre_tick_o,
  output logic       div_tick_o,
  output logic       frame_tick_o
);

  localparam int unsigned EXP_MAX = (12 > PRESC_SHIFT_DROP) ? 12 - PRESC_SHIFT_DROP : 0;
  localparam int unsigned PW      = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic          en;
  logic          run_q;
  logic          active;
  logic          clr;
  logic          ctrl_rsv_unused;
  cfg_t          cfg;
  logic [PW-1:0] n_last;
  logic [2:0]    d_last;
  logic [2:0]    k_last;

  assign en              = ctrl_i[7];
  assign ctrl_rsv_unused = ctrl_i[3];
  assign active          = en & run_q;
  assign clr             = ~active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en;
  end

  // setting is captured while idle and at each frame boundary
  lcd_fclk_cfg #(.SHIFT_DROP(PRESC_SHIFT_DROP), .PW(PW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (~run_q | frame_tick_o),
    .presc_i  (ctrl_i[6:4]),
    .div_i    (ctrl_i[2:0]),
    .duty_i   (duty_i),
    .cfg_o    (cfg),
    .n_last_o (n_last),
    .d_last_o (d_last),
    .k_last_o (k_last)
  );

  lcd_fclk_stage #(.W(PW)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (active),
    .last_i (n_last),
    .tick_o (pre_tick_o)
  );

  lcd_fclk_stage #(.W(3)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (pre_tick_o),
    .last_i (d_last),
    .tick_o (div_tick_o)
  );

  lcd_fclk_stage #(.W(3)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (div_tick_o),
    .last_i (k_last),
    .tick_o (frame_tick_o)
  );

  assign ctrl_o = {run_q, cfg.presc, 1'b0, cfg.div};

  a_r8_frame_nests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_o |-> div_tick_o && pre_tick_o);

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pre_tick_o && !div_tick_o && !frame_tick_o);

  a_r5_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !frame_tick_o |=> $stable(cfg));

  a_r3_frame_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_tick_o |=> !frame_tick_o);

endmodule

// File: tb/lcd_frame_clk_tb_top.sv
`timescale 1ns/1ps
module lcd_frame_clk_tb_top;

  localparam int unsigned DROP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic [1:0] duty = 2'b00;
  logic [7:0] ctrl_o;
  logic       pre_tick, div_tick, frame_tick;
  int         checks = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  lcd_frame_clk #(.PRESC_SHIFT_DROP(DROP)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_i       (ctrl),
    .duty_i       (duty),
    .ctrl_o       (ctrl_o),
    .pre_tick_o   (pre_tick),
    .div_tick_o   (div_tick),
    .frame_tick_o (frame_tick)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_n(input int sel);
    int full;
    full = (sel == 0) ? 16 : (1 << (sel + 5));
    return ((full >> DROP) > 0) ? (full >> DROP) : 1;
  endfunction

  function automatic int exp_k(input int d);
    return (d == 2) ? 6 : 8;
  endfunction

  // waits for the next frame pulse, then measures up to the one after it
  task automatic measure(output int per, output int np, output int nd, output bit nest);
    @(negedge clk);
    while (!frame_tick) @(negedge clk);
    per = 0; np = 0; nd = 0;
    do begin
      @(negedge clk);
      per++;
      np += int'(pre_tick);
      nd += int'(div_tick);
    end while (!frame_tick);
    nest = pre_tick & div_tick;
  endtask

  task automatic run_combo(input int s, input int d, input int u, input bit rsv);
    int per, np, nd;
    bit nest;
    int n, dd, k;
    ctrl = {1'b1, 3'(s), rsv, 3'(d)};
    duty = 2'(u);
    measure(per, np, nd, nest);
    n = exp_n(s); dd = d + 1; k = exp_k(u);
    chk(per == k * n * dd, "R3", $sformatf("frame period s%0d d%0d u%0d", s, d, u), per, k * n * dd);
    chk(np == k * dd, "R1", $sformatf("prescaler pulses per frame s%0d d%0d u%0d", s, d, u), np, k * dd);
    chk(nd == k, "R2", $sformatf("divider pulses per frame s%0d d%0d u%0d", s, d, u), nd, k);
    chk(nest, "R8", "frame pulse without coinciding stage pulses", int'(nest), 1);
    chk(ctrl_o == {1'b1, 3'(s), 1'b0, 3'(d)}, "R4", "readback", int'(ctrl_o),
        int'({1'b1, 3'(s), 1'b0, 3'(d)}));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c, cnt;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk({ctrl_o, pre_tick, div_tick, frame_tick} == 11'd0, "R7", "outputs in reset",
        int'({ctrl_o, pre_tick, div_tick, frame_tick}), 0);
    rst_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cnt += int'(pre_tick | div_tick | frame_tick);
    end
    chk(cnt == 0, "R6", "pulses while disabled after reset", cnt, 0);
    chk(ctrl_o == 8'h00, "R7", "readback after reset", int'(ctrl_o), 0);

    // all divide codes, duties 1/2 and 1/3, four smallest prescalers
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 8; d++)
        for (int u = 1; u < 3; u++)
          run_combo(s, d, u, 1'((s + d + u) % 2));
    // remaining prescaler codes
    for (int s = 4; s < 8; s++) run_combo(s, 0, 3, 1'b1);
    // static and 1/4 duties
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 8; d++) begin
        run_combo(s, d, 0, 1'(d % 2));
        run_combo(s, d, 3, 1'((d + 1) % 2));
      end

    // R5: mid-frame change keeps the running period
    run_combo(1, 3, 3, 1'b0);               // period 8*4*4 = 128
    for (int i = 0; i < 20; i++) @(negedge clk);
    ctrl = {1'b1, 3'd0, 1'b0, 3'd0};
    duty = 2'b10;
    c = 20;
    @(negedge clk);
    c++;
    chk(ctrl_o[6:4] == 3'd1, "R5", "setting applied mid-frame", int'(ctrl_o[6:4]), 1);
    while (!frame_tick) begin @(negedge clk); c++; end
    chk(c == 128, "R5", "period after mid-frame change", c, 128);
    c = 0;
    do begin @(negedge clk); c++; end while (!frame_tick);
    chk(c == 6, "R5", "period under new setting", c, 6);

    // R6: disable mid-frame, setting tracks, restart latency
    for (int i = 0; i < 3; i++) @(negedge clk);
    ctrl = {1'b0, 3'd2, 1'b1, 3'd1};
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cnt += int'(pre_tick | div_tick | frame_tick);
    end
    chk(cnt == 0, "R6", "pulses while disabled", cnt, 0);
    chk(ctrl_o == {1'b0, 3'd2, 1'b0, 3'd1}, "R4", "reserved bit and idle tracking", int'(ctrl_o),
        int'({1'b0, 3'd2, 1'b0, 3'd1}));
    ctrl = {1'b1, 3'd0, 1'b1, 3'd0};
    duty = 2'b10;
    c = 0;
    do begin @(negedge clk); c++; end while (!frame_tick && c < 1000);
    chk(c == 6, "R6", "first frame latency after enable", c, 6);
    chk(ctrl_o[3] == 1'b0, "R4", "reserved bit while running", int'(ctrl_o[3]), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule